// File: doc/BRIEF.md
# Carrier-Sense Interframe Gap Timer

This block decides when a half-duplex Ethernet transmitter may begin its next frame. The transmitter pulses an end-of-transmit or backoff-complete input. The timer then waits for the line to go quiet and counts an interframe gap of 96 bit times. During that wait it watches carrier sense in two phases. Carrier seen in the early part of the gap throws the count away. Carrier seen in the late part is disregarded, so the frame still leaves on time. Once the gap has run and a frame is waiting, a transmit-permit output goes high. It stays high until the frame start is signalled.

All counting advances only on a one-bit-time strobe. The same logic therefore serves any line rate; only the strobe rate changes. In full-duplex operation, carrier sense plays no part and only the gap after the last transmission is kept. A separate receive-side path times the idle interval between received frames. It raises a one-cycle flag when a new frame begins fewer than 28 bit times after the previous one ended.

Top module: `ifg_timer`

## Requirements
- R1: After reset, tx_permit and rx_early are low, and tx_permit stays low until a full 96-strobe gap has elapsed, even with tx_req high.
- R2: After a tx_end pulse with carrier idle, tx_permit (with tx_req high) rises on the 96th bit_en strobe and not on the 95th.
- R3: While carrier sense is high after tx_end or backoff_done, the gap count does not begin; the 96 strobes start with the first idle strobe.
- R4: Carrier sense high on any of the first 60 strobes of the gap discards the count; a fresh 96-strobe gap begins once carrier drops.
- R5: Carrier sense high on strobes 61 to 96 of the gap is ignored, and tx_permit rises on the 96th strobe as scheduled.
- R6: A backoff_done pulse restarts the gap exactly as tx_end does, and tx_permit is low in the cycle after either pulse.
- R7: tx_permit is high only when the gap is complete and tx_req is high; a tx_start while permitted drops tx_permit from the next cycle until a later gap completes.
- R8: With full_duplex high, carrier sense is ignored throughout and tx_permit rises after 96 strobes.
- R9: Clock cycles without bit_en leave both gap counts unchanged.
- R10: When rx_dv rises after at least 28 bit_en strobes with rx_dv low, rx_early stays low. With fewer than 28 strobes, rx_early is high for exactly the one cycle after the rising edge.
- R11: The first received frame after reset is never flagged by rx_early.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One-bit-time strobe that advances all counting |
| full_duplex | input | 1 | High to ignore carrier sense |
| crs | input | 1 | Carrier sense from the line |
| tx_end | input | 1 | Pulse when a transmission finishes |
| backoff_done | input | 1 | Pulse when the backoff wait finishes |
| tx_req | input | 1 | A frame is pending for transmission |
| tx_start | input | 1 | Pulse when the pending frame begins |
| rx_dv | input | 1 | High while a received frame is in progress |
| tx_permit | output | 1 | Transmission may start now |
| rx_early | output | 1 | One-cycle flag: the frame just begun followed the last too closely |

## Verification
The gap is exercised with four kinds of carrier pattern. A quiet line checks the bare 95/96 boundary. Carrier held from the end pulse shows that the count waits for idle. Carrier on strobe 60 versus strobe 61 separates the restart window from the ignore window. Carrier during full duplex shows that the input is masked entirely. Separate runs hold the strobe low for long stretches, to tell cycles apart from bit times. The receive path is tried with gaps of 27, 28, a very short one and a very long one, which isolates the threshold and its saturation.

// File: rtl/ifg_timer.sv
module ifg_timer #(
  parameter int GAP_BITS    = 96,
  parameter int OPEN_BITS   = 60,
  parameter int RX_MIN_BITS = 28
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic full_duplex,
  input  logic crs,
  input  logic tx_end,
  input  logic backoff_done,
  input  logic tx_req,
  input  logic tx_start,
  input  logic rx_dv,
  output logic tx_permit,
  output logic rx_early
);
  localparam int CW = $clog2(GAP_BITS + 1);
  localparam int RW = $clog2(RX_MIN_BITS + 1);
  localparam logic [CW-1:0] GAP_LAST = CW'(GAP_BITS - 1);
  localparam logic [CW-1:0] GAP_FULL = CW'(GAP_BITS);
  localparam logic [CW-1:0] OPEN_LIM = CW'(OPEN_BITS);
  localparam logic [RW-1:0] RX_LIM   = RW'(RX_MIN_BITS);

  typedef enum logic [1:0] {S_WAIT, S_GAP, S_READY, S_SEND} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [RW-1:0] rx_cnt;
  logic          rx_dv_q;
  logic          busy;

  assign busy      = crs & ~full_duplex;
  assign tx_permit = (st == S_READY) & tx_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= S_WAIT;
      cnt <= '0;
    end else if (tx_end || backoff_done) begin
      st  <= S_WAIT;
      cnt <= '0;
    end else begin
      case (st)
        S_WAIT:
          if (bit_en && !busy) begin
            st  <= S_GAP;
            cnt <= CW'(1);
          end
        S_GAP:
          if (bit_en) begin
            if (busy && cnt < OPEN_LIM) begin
              st  <= S_WAIT;
              cnt <= '0;
            end else if (cnt == GAP_LAST) begin
              st  <= S_READY;
              cnt <= GAP_FULL;
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
        S_READY:
          if (tx_start && tx_req) st <= S_SEND;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_cnt   <= RX_LIM;
      rx_dv_q  <= 1'b0;
      rx_early <= 1'b0;
    end else begin
      rx_dv_q  <= rx_dv;
      rx_early <= rx_dv && !rx_dv_q && (rx_cnt < RX_LIM);
      if (rx_dv)
        rx_cnt <= '0;
      else if (bit_en && rx_cnt < RX_LIM)
        rx_cnt <= rx_cnt + RW'(1);
    end
  end
endmodule

// File: rtl/ifg_timer_chk.sv
module ifg_timer_chk #(
  parameter int GAP_BITS = 96
) (
  input logic clk,
  input logic rst_n,
  input logic bit_en,
  input logic tx_end,
  input logic backoff_done,
  input logic tx_req,
  input logic tx_start,
  input logic rx_dv,
  input logic tx_permit,
  input logic rx_early
);
  localparam int SW = $clog2(GAP_BITS + 2);
  localparam logic [SW-1:0] SAT = SW'(GAP_BITS + 1);

  logic [SW-1:0] seen;

  always_ff @(posedge clk) begin
    if (!rst_n) seen <= '0;
    else if (tx_end || backoff_done) seen <= '0;
    else if (bit_en && seen < SAT) seen <= seen + SW'(1);
  end

  a_r7_permit_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    tx_permit |-> tx_req);

  a_r2_gap_elapsed: assert property (@(posedge clk) disable iff (!rst_n)
    tx_permit |-> (seen >= SW'(GAP_BITS)));

  a_r7_drop_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_permit && tx_start) |=> !tx_permit);

  a_r6_restart_blocks_permit: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_end || backoff_done) |=> !tx_permit);

  a_r10_flag_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
    rx_early |-> $past(rx_dv));
endmodule

bind ifg_timer ifg_timer_chk #(.GAP_BITS(GAP_BITS)) i_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .tx_end(tx_end),
  .backoff_done(backoff_done), .tx_req(tx_req), .tx_start(tx_start),
  .rx_dv(rx_dv), .tx_permit(tx_permit), .rx_early(rx_early)
);

// File: tb/test_ifg_timer.sv
module test_ifg_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b0, full_duplex = 1'b0, crs = 1'b0;
  logic tx_end = 1'b0, backoff_done = 1'b0, tx_req = 1'b0, tx_start = 1'b0;
  logic rx_dv = 1'b0;
  logic tx_permit, rx_early;
  int n_cmp = 0, n_bad = 0;
  bit ended = 1'b0;

  always #2 clk = ~clk;

  ifg_timer i_ifg_timer (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .full_duplex(full_duplex),
    .crs(crs), .tx_end(tx_end), .backoff_done(backoff_done), .tx_req(tx_req),
    .tx_start(tx_start), .rx_dv(rx_dv), .tx_permit(tx_permit), .rx_early(rx_early)
  );

  // {full_duplex, idle strobes, carrier strobes, idle strobes, expected permit}
  localparam logic [25:0] VEC [11] = '{
    {1'b0, 8'd96, 8'd0,  8'd0,  1'b1},  // R2
    {1'b0, 8'd95, 8'd0,  8'd0,  1'b0},  // R2
    {1'b0, 8'd0,  8'd20, 8'd96, 1'b1},  // R3
    {1'b0, 8'd0,  8'd20, 8'd95, 1'b0},  // R3
    {1'b0, 8'd59, 8'd1,  8'd95, 1'b0},  // R4
    {1'b0, 8'd59, 8'd1,  8'd96, 1'b1},  // R4
    {1'b0, 8'd30, 8'd5,  8'd95, 1'b0},  // R4
    {1'b0, 8'd60, 8'd1,  8'd35, 1'b1},  // R5
    {1'b0, 8'd60, 8'd36, 8'd0,  1'b1},  // R5
    {1'b1, 8'd10, 8'd50, 8'd36, 1'b1},  // R8
    {1'b1, 8'd10, 8'd50, 8'd35, 1'b0}   // R8
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic tick(input logic en);
    bit_en = en;
    @(posedge clk);
    @(negedge clk);
    bit_en = 1'b0;
  endtask

  task automatic pulse_end(input logic via_backoff);
    if (via_backoff) backoff_done = 1'b1; else tx_end = 1'b1;
    tick(1'b0);
    backoff_done = 1'b0;
    tx_end = 1'b0;
  endtask

  task automatic rx_gap(input int gap, input logic exp, input string tag);
    rx_dv = 1'b1;
    repeat (8) tick(1'b1);
    rx_dv = 1'b0;
    repeat (gap) tick(1'b1);
    rx_dv = 1'b1;
    tick(1'b1);
    chk(tag, rx_early, exp);
    tick(1'b1);
    chk({tag, " one cycle"}, rx_early, 1'b0);
  endtask

  task automatic finish_run;
    if (!ended) begin
      ended = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    tx_req = 1'b1;
    repeat (3) tick(1'b1);
    rst_n = 1'b1;
    chk("R1 permit after reset", tx_permit, 1'b0);
    chk("R1 rx_early after reset", rx_early, 1'b0);
    repeat (95) tick(1'b1);
    chk("R1 95 strobes from reset", tx_permit, 1'b0);
    tick(1'b1);
    chk("R1 96 strobes from reset", tx_permit, 1'b1);

    foreach (VEC[i]) begin
      logic [25:0] v;
      v = VEC[i];
      full_duplex = v[25];
      pulse_end(1'b0);
      crs = 1'b0;
      repeat (int'(v[24:17])) tick(1'b1);
      crs = 1'b1;
      repeat (int'(v[16:9])) tick(1'b1);
      crs = 1'b0;
      repeat (int'(v[8:1])) tick(1'b1);
      chk($sformatf("gap vector %0d (R2 R3 R4 R5 R8)", i), tx_permit, v[0]);
    end
    full_duplex = 1'b0;

    // R6: backoff_done restarts the gap
    repeat (40) tick(1'b1);
    chk("R6 ready before backoff", tx_permit, 1'b1);
    pulse_end(1'b1);
    chk("R6 low after backoff", tx_permit, 1'b0);
    repeat (95) tick(1'b1);
    chk("R6 95 strobes", tx_permit, 1'b0);
    tick(1'b1);
    chk("R6 96 strobes", tx_permit, 1'b1);

    // R7: request gating and drop on start
    tx_req = 1'b0;
    #1;
    chk("R7 no request", tx_permit, 1'b0);
    tx_req = 1'b1;
    #1;
    chk("R7 request again", tx_permit, 1'b1);
    tx_start = 1'b1;
    tick(1'b1);
    tx_start = 1'b0;
    chk("R7 drop on start", tx_permit, 1'b0);
    repeat (120) tick(1'b1);
    chk("R7 stays low while sending", tx_permit, 1'b0);

    // R9: cycles without strobe do not count
    pulse_end(1'b0);
    repeat (95) tick(1'b1);
    repeat (50) tick(1'b0);
    chk("R9 idle cycles not counted", tx_permit, 1'b0);
    tick(1'b1);
    chk("R9 96th strobe", tx_permit, 1'b1);

    // Receive gap checks
    rx_dv = 1'b1;
    tick(1'b1);
    chk("R11 first frame", rx_early, 1'b0);
    rx_gap(27, 1'b1, "R10 gap 27");
    rx_gap(28, 1'b0, "R10 gap 28");
    rx_gap(3, 1'b1, "R10 gap 3");
    rx_gap(150, 1'b0, "R10 gap 150");
    // R9 on receive: non-strobe cycles do not count
    rx_dv = 1'b1;
    repeat (4) tick(1'b1);
    rx_dv = 1'b0;
    repeat (27) tick(1'b1);
    repeat (30) tick(1'b0);
    rx_dv = 1'b1;
    tick(1'b0);
    chk("R9 rx idle cycles not counted", rx_early, 1'b1);
    rx_dv = 1'b0;
    tick(1'b0);

    finish_run();
  end
endmodule